// File: doc/BRIEF.md
# Configuration Access Request Checker

This block screens configuration read and write requests that arrive from a host command port before they reach a small set of per-function configuration register files. Each request carries a packed address, an access size, argument and result counts, a 64-bit bridge identifier and, for writes, a data word. The block does four things with each request:

- It extracts the device/function number and a 12-bit register offset from the packed address.
- It confirms that the request is addressed to this bridge and to a function that exists.
- It checks the access size, the natural alignment of the access and the offset bound of the target function.
- It either performs the byte-enabled access or rejects the request.

Every request produces exactly one registered response, one clock later, marked by a single-cycle valid pulse. The response carries a status word and, for successful reads, the data. Each function's configuration space is either 256 or 4096 bytes, chosen per function by a parameter. Data is little-endian.

Top module: `cfg_req_checker`

## Requirements
- R1: While reset is asserted, and after it is released, `rsp_valid_o` is low until a request arrives. Every register word of every function reads back as zero after reset.
- R2: Each cycle with `req_valid_i` high produces exactly one response, with `rsp_valid_o` high in the following cycle. `rsp_valid_o` is never high in a cycle that does not follow a request.
- R3: The argument and result counts must match the request type:
  - a read must carry `req_nargs_i`=4 and `req_nret_i`=2;
  - a write must carry `req_nargs_i`=5 and `req_nret_i`=1.
  Any other pair gives status 32'hFFFF_FFFF and performs no access.
- R4: An access size (`req_size_i`) other than 1, 2 or 4 gives status 32'hFFFF_FFFF and performs no access.
- R5: The offset must be a multiple of the size. A 2-byte access with offset bit 0 set, or a 4-byte access with offset bits [1:0] non-zero, gives status 32'hFFFF_FFFF and performs no access.
- R6: The 12-bit offset is `{req_addr_i[31:28], req_addr_i[7:0]}`. The offset bound depends on the target function:
  - a function whose `FUNC_EXT` bit is 0 has a 256-byte space, so an offset of 256 or more gives status 32'hFFFF_FFFF;
  - a function whose `FUNC_EXT` bit is 1 accepts offsets up to 4095.
- R7: The device/function number is `req_addr_i[15:8]`. The request fails with status 32'hFFFF_FFFF if either of these holds:
  - the number is not below `NUM_FUNCS`;
  - `{req_bid_hi_i, req_bid_lo_i}` (high word first) differs from `BRIDGE_ID`.
- R8: A successful read responds with status 0, `rsp_words_o`=2, and `rsp_data_o` holding the addressed bytes. The byte at the offset goes to bits [7:0], the next byte up to bits [15:8], and so on, zero-extended.
- R9: A successful write responds with status 0, `rsp_words_o`=1 and `rsp_data_o`=0. It changes only the bytes it addresses: the low `req_size_i` bytes of `req_wdata_i` go to lanes starting at offset[1:0].
- R10: Each function stores `DEPTH` 32-bit words. The word is selected by offset bits [2 +: log2(DEPTH)], and higher offset bits alias onto the same storage.
- R11: A rejected request responds with `rsp_words_o`=1 and `rsp_data_o`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_nargs_i | input | 4 | Argument count carried by the request |
| req_nret_i | input | 4 | Result count expected by the requester |
| req_bid_hi_i | input | 32 | Bridge identifier, high word |
| req_bid_lo_i | input | 32 | Bridge identifier, low word |
| req_addr_i | input | 32 | Packed configuration address |
| req_size_i | input | 8 | Access size in bytes |
| req_wdata_i | input | 32 | Write data, least significant bytes used |
| rsp_valid_o | output | 1 | One-cycle response strobe |
| rsp_status_o | output | 32 | 0 on success, 32'hFFFF_FFFF on rejection |
| rsp_data_o | output | 32 | Read data, zero otherwise |
| rsp_words_o | output | 2 | Number of meaningful response words (1 or 2) |

## Verification
The hardest case to produce is a rejected write whose lack of effect must be seen. The block has no side channel, so the bench follows every rejected write with a legal read of the same word and compares the result against its own byte-level storage model. Offsets with high bits set are reached by placing address bits [31:28] separately from the low byte. The same physical word is approached through an extended function's aliased offset, and through a plain function's out-of-bounds offset. Back-to-back write-then-read pairs check that a read sees a write made in the immediately preceding cycle.

// File: rtl/cfg_chk_pkg.sv
package cfg_chk_pkg;
  localparam logic [31:0] ST_OK   = 32'h0000_0000;
  localparam logic [31:0] ST_FAIL = 32'hFFFF_FFFF;
  localparam logic [3:0]  RD_NARGS = 4'd4;
  localparam logic [3:0]  RD_NRET  = 4'd2;
  localparam logic [3:0]  WR_NARGS = 4'd5;
  localparam logic [3:0]  WR_NRET  = 4'd1;

  typedef struct packed {
    logic [7:0]  devfn;
    logic [11:0] off;
  } cfg_loc_t;
endpackage

// File: rtl/cfg_addr_decode.sv
module cfg_addr_decode
  import cfg_chk_pkg::*;
(
  input  logic [31:0] addr_i,
  output cfg_loc_t    loc_o
);
  // high nibble of the address supplies offset bits 11:8
  assign loc_o.devfn = addr_i[15:8];
  assign loc_o.off   = {addr_i[31:28], addr_i[7:0]};
endmodule

// File: rtl/cfg_req_validate.sv
module cfg_req_validate
  import cfg_chk_pkg::*;
#(
  parameter int unsigned          NUM_FUNCS = 4,
  parameter logic [NUM_FUNCS-1:0] FUNC_EXT  = '0,
  parameter logic [63:0]          BRIDGE_ID = 64'h0,
  localparam int unsigned         FW        = (NUM_FUNCS > 1) ? $clog2(NUM_FUNCS) : 1
) (
  input  logic          write_i,
  input  logic [3:0]    nargs_i,
  input  logic [3:0]    nret_i,
  input  logic [63:0]   bid_i,
  input  logic [7:0]    size_i,
  input  cfg_loc_t      loc_i,
  output logic          ok_o,
  output logic [FW-1:0] func_o,
  output logic [3:0]    be_o
);
  logic args_ok, size_ok, aligned, dev_hit, in_bounds;
  logic [1:0] lane;

  assign lane   = loc_i.off[1:0];
  assign func_o = loc_i.devfn[FW-1:0];

  always_comb begin
    if (write_i) args_ok = (nargs_i == WR_NARGS) && (nret_i == WR_NRET);
    else         args_ok = (nargs_i == RD_NARGS) && (nret_i == RD_NRET);
  end

  always_comb begin
    size_ok = 1'b1;
    aligned = 1'b1;
    be_o    = 4'b1111;
    case (size_i)
      8'd1: be_o = 4'b0001 << lane;
      8'd2: begin be_o = 4'b0011 << lane; aligned = ~lane[0]; end
      8'd4: aligned = (lane == 2'b00);
      default: size_ok = 1'b0;
    endcase
  end

  assign dev_hit   = (bid_i == BRIDGE_ID) && ({24'd0, loc_i.devfn} < NUM_FUNCS);
  assign in_bounds = FUNC_EXT[func_o] || (loc_i.off[11:8] == 4'd0);
  assign ok_o      = args_ok && size_ok && aligned && dev_hit && in_bounds;
endmodule

// File: rtl/cfg_func_regs.sv
module cfg_func_regs #(
  parameter int unsigned  NUM_FUNCS = 4,
  parameter int unsigned  DEPTH     = 16,
  localparam int unsigned FW        = (NUM_FUNCS > 1) ? $clog2(NUM_FUNCS) : 1,
  localparam int unsigned DW        = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [FW-1:0] func_i,
  input  logic [DW-1:0] word_i,
  input  logic [3:0]    be_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o
);
  logic [NUM_FUNCS-1:0][31:0] rd_word;

  for (genvar f = 0; f < NUM_FUNCS; f++) begin : g_func
    logic [31:0] mem_q [DEPTH];
    logic        sel;
    assign sel = we_i && (func_i == FW'(f));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int w = 0; w < DEPTH; w++) mem_q[w] <= '0;
      end else if (sel) begin
        for (int b = 0; b < 4; b++)
          if (be_i[b]) mem_q[word_i][8*b +: 8] <= wdata_i[8*b +: 8];
      end
    end

    assign rd_word[f] = mem_q[word_i];
  end

  assign rdata_o = rd_word[func_i];
endmodule

// File: rtl/cfg_req_checker.sv
module cfg_req_checker
  import cfg_chk_pkg::*;
#(
  parameter int unsigned          NUM_FUNCS = 4,
  parameter logic [NUM_FUNCS-1:0] FUNC_EXT  = 4'b1010,
  parameter int unsigned          DEPTH     = 16,
  parameter logic [63:0]          BRIDGE_ID = 64'h0000_0800_2000_0001
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  input  logic        req_write_i,
  input  logic [3:0]  req_nargs_i,
  input  logic [3:0]  req_nret_i,
  input  logic [31:0] req_bid_hi_i,
  input  logic [31:0] req_bid_lo_i,
  input  logic [31:0] req_addr_i,
  input  logic [7:0]  req_size_i,
  input  logic [31:0] req_wdata_i,
  output logic        rsp_valid_o,
  output logic [31:0] rsp_status_o,
  output logic [31:0] rsp_data_o,
  output logic [1:0]  rsp_words_o
);
  localparam int unsigned FW = (NUM_FUNCS > 1) ? $clog2(NUM_FUNCS) : 1;
  localparam int unsigned DW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  cfg_loc_t      loc;
  logic          ok;
  logic [FW-1:0] func;
  logic [3:0]    be;
  logic [4:0]    shamt;
  logic [31:0]   rword, rshift, rval, wlane;

  cfg_addr_decode u_dec (.addr_i(req_addr_i), .loc_o(loc));

  cfg_req_validate #(
    .NUM_FUNCS(NUM_FUNCS), .FUNC_EXT(FUNC_EXT), .BRIDGE_ID(BRIDGE_ID)
  ) u_val (
    .write_i(req_write_i), .nargs_i(req_nargs_i), .nret_i(req_nret_i),
    .bid_i({req_bid_hi_i, req_bid_lo_i}), .size_i(req_size_i), .loc_i(loc),
    .ok_o(ok), .func_o(func), .be_o(be)
  );

  assign shamt = {loc.off[1:0], 3'b000};
  assign wlane = req_wdata_i << shamt;

  cfg_func_regs #(.NUM_FUNCS(NUM_FUNCS), .DEPTH(DEPTH)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .we_i(req_valid_i && req_write_i && ok),
    .func_i(func), .word_i(loc.off[2 +: DW]), .be_i(be),
    .wdata_i(wlane), .rdata_o(rword)
  );

  assign rshift = rword >> shamt;
  always_comb begin
    case (req_size_i)
      8'd1:    rval = {24'd0, rshift[7:0]};
      8'd2:    rval = {16'd0, rshift[15:0]};
      default: rval = rshift;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o  <= 1'b0;
      rsp_status_o <= ST_OK;
      rsp_data_o   <= '0;
      rsp_words_o  <= 2'd0;
    end else begin
      rsp_valid_o <= req_valid_i;
      if (req_valid_i) begin
        rsp_status_o <= ok ? ST_OK : ST_FAIL;
        rsp_data_o   <= (ok && !req_write_i) ? rval : '0;
        rsp_words_o  <= (ok && !req_write_i) ? 2'd2 : 2'd1;
      end
    end
  end
endmodule

// File: rtl/cfg_req_checker_sva.sv
module cfg_req_checker_sva (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic        req_write_i,
  input logic [3:0]  req_nargs_i,
  input logic [3:0]  req_nret_i,
  input logic [31:0] req_addr_i,
  input logic [7:0]  req_size_i,
  input logic        rsp_valid_o,
  input logic [31:0] rsp_status_o,
  input logic [31:0] rsp_data_o,
  input logic [1:0]  rsp_words_o
);
  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o); // R2
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o); // R2
  AST_BAD_ARGS_FAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && (req_write_i ? (req_nargs_i != 4'd5 || req_nret_i != 4'd1)
                                 : (req_nargs_i != 4'd4 || req_nret_i != 4'd2)))
    |=> rsp_status_o == 32'hFFFF_FFFF); // R3
  AST_BAD_SIZE_FAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_size_i != 8'd1 && req_size_i != 8'd2 && req_size_i != 8'd4)
    |=> rsp_status_o == 32'hFFFF_FFFF); // R4
  AST_MISALIGN_FAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && ((req_size_i == 8'd2 && req_addr_i[0]) ||
                     (req_size_i == 8'd4 && req_addr_i[1:0] != 2'b00)))
    |=> rsp_status_o == 32'hFFFF_FFFF); // R5
  AST_WRITE_ONE_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_write_i) |=> (rsp_words_o == 2'd1 && rsp_data_o == 32'd0)); // R9
  AST_FAIL_SHAPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_status_o != 32'd0) |-> (rsp_words_o == 2'd1 && rsp_data_o == 32'd0)); // R11
  AST_STATUS_CODES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (rsp_status_o == 32'd0 || rsp_status_o == 32'hFFFF_FFFF)); // R8
endmodule

bind cfg_req_checker cfg_req_checker_sva u_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i),
  .req_write_i(req_write_i), .req_nargs_i(req_nargs_i), .req_nret_i(req_nret_i),
  .req_addr_i(req_addr_i), .req_size_i(req_size_i), .rsp_valid_o(rsp_valid_o),
  .rsp_status_o(rsp_status_o), .rsp_data_o(rsp_data_o), .rsp_words_o(rsp_words_o)
);

// File: tb/tb_cfg_req_checker.sv
`timescale 1ns/1ps
module tb_cfg_req_checker;
  localparam logic [63:0] BID = 64'h0000_0800_2000_0001;
  localparam logic [3:0]  EXT = 4'b1010;
  localparam logic [31:0] FAILW = 32'hFFFF_FFFF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [3:0] req_nargs = '0, req_nret = '0;
  logic [31:0] bid_hi = '0, bid_lo = '0, req_addr = '0, req_wdata = '0;
  logic [7:0] req_size = '0;
  logic rsp_valid;
  logic [31:0] rsp_status, rsp_data;
  logic [1:0] rsp_words;

  int checks = 0, errors = 0;
  bit done = 0;
  logic req_seen = 1'b0;

  typedef struct { logic [31:0] st; logic [31:0] dat; logic [1:0] w; string tag; } exp_t;
  exp_t q[$];
  logic [31:0] model [4][16];

  always #2.5 clk = ~clk;

  cfg_req_checker dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_write_i(req_write),
    .req_nargs_i(req_nargs), .req_nret_i(req_nret), .req_bid_hi_i(bid_hi),
    .req_bid_lo_i(bid_lo), .req_addr_i(req_addr), .req_size_i(req_size),
    .req_wdata_i(req_wdata), .rsp_valid_o(rsp_valid), .rsp_status_o(rsp_status),
    .rsp_data_o(rsp_data), .rsp_words_o(rsp_words)
  );

  function automatic logic [31:0] mk_addr(logic [7:0] devfn, logic [11:0] off);
    return {off[11:8], 12'd0, devfn, off[7:0]};
  endfunction

  task automatic check(bit cond, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: compute expectation from the requirements, push to scoreboard
  task automatic send(bit wr, logic [3:0] na, logic [3:0] nr, logic [63:0] bid,
                      logic [31:0] addr, logic [7:0] size, logic [31:0] wd, string tag);
    exp_t e;
    logic [11:0] off;
    logic [7:0] devfn;
    bit ok;
    logic [31:0] word;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_nargs = na; req_nret = nr;
    {bid_hi, bid_lo} = bid; req_addr = addr; req_size = size; req_wdata = wd;
    off = {addr[31:28], addr[7:0]};
    devfn = addr[15:8];
    ok = (wr ? (na == 4'd5 && nr == 4'd1) : (na == 4'd4 && nr == 4'd2));
    ok = ok && (size == 8'd1 || size == 8'd2 || size == 8'd4);
    ok = ok && (bid == BID) && (devfn < 8'd4);
    ok = ok && ((off % {4'd0, size}) == 12'd0 || size == 8'd0);
    if (ok) ok = EXT[devfn[1:0]] || (off < 12'd256);
    e.tag = tag;
    if (!ok) begin
      e.st = FAILW; e.dat = '0; e.w = 2'd1;
    end else if (wr) begin
      for (int b = 0; b < 4; b++)
        if (b < int'(size)) model[devfn[1:0]][off[5:2]][8*(int'(off[1:0])+b) +: 8] = wd[8*b +: 8];
      e.st = '0; e.dat = '0; e.w = 2'd1;
    end else begin
      word = model[devfn[1:0]][off[5:2]] >> (8 * off[1:0]);
      if (size == 8'd1) word = word & 32'hFF;
      if (size == 8'd2) word = word & 32'hFFFF;
      e.st = '0; e.dat = word; e.w = 2'd2;
    end
    q.push_back(e);
  endtask

  task automatic rd(logic [7:0] f, logic [11:0] off, logic [7:0] size, string tag);
    send(1'b0, 4'd4, 4'd2, BID, mk_addr(f, off), size, 32'd0, tag);
  endtask
  task automatic wr(logic [7:0] f, logic [11:0] off, logic [7:0] size, logic [31:0] d, string tag);
    send(1'b1, 4'd5, 4'd1, BID, mk_addr(f, off), size, d, tag);
  endtask
  task automatic idle(int n);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (n - 1) @(negedge clk);
  endtask

  always @(posedge clk) req_seen <= req_valid && rst_n;

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (req_seen || rsp_valid)
        check(rsp_valid == req_seen, "R2 response timing", 32'(rsp_valid), 32'(req_seen));
      if (rsp_valid) begin
        if (q.size() == 0) begin
          check(1'b0, "R2 response without request", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(rsp_status == e.st, {e.tag, " status"}, rsp_status, e.st);
          check(rsp_data == e.dat, {e.tag, " data"}, rsp_data, e.dat);
          check(rsp_words == e.w, {e.tag, " words"}, 32'(rsp_words), 32'(e.w));
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog expired actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int f = 0; f < 4; f++) for (int w = 0; w < 16; w++) model[f][w] = '0;
    repeat (3) @(negedge clk);
    check(rsp_valid == 1'b0, "R1 valid low in reset", 32'(rsp_valid), 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(rsp_valid == 1'b0, "R1 valid low after reset", 32'(rsp_valid), 32'd0);
    rd(8'd2, 12'h020, 8'd4, "R1 cleared storage");
    rd(8'd3, 12'h03C, 8'd4, "R1 cleared storage");
    idle(2);
    // R8 R9 basic word and byte lanes, back-to-back write then read (R2)
    wr(8'd0, 12'h010, 8'd4, 32'hDEAD_BEEF, "R9 word write");
    rd(8'd0, 12'h010, 8'd4, "R8 word read");
    wr(8'd0, 12'h011, 8'd1, 32'hFFFF_FF55, "R9 byte write lane1");
    rd(8'd0, 12'h010, 8'd4, "R9 only addressed byte changed");
    rd(8'd0, 12'h013, 8'd1, "R8 byte read lane3");
    rd(8'd0, 12'h012, 8'd2, "R8 half read upper");
    wr(8'd2, 12'h026, 8'd2, 32'h1234_A5C3, "R9 half write upper");
    rd(8'd2, 12'h024, 8'd4, "R8 word after half write");
    idle(3);
    // R4 illegal sizes, then confirm untouched
    wr(8'd0, 12'h010, 8'd3, 32'h0, "R4 size 3");
    wr(8'd0, 12'h010, 8'd0, 32'h0, "R4 size 0");
    wr(8'd0, 12'h010, 8'd8, 32'h0, "R4 size 8");
    rd(8'd0, 12'h010, 8'd4, "R4 no access done");
    // R5 misalignment
    wr(8'd1, 12'h011, 8'd2, 32'hAAAA, "R5 half at odd");
    wr(8'd1, 12'h012, 8'd4, 32'hBBBB_BBBB, "R5 word at 2");
    rd(8'd1, 12'h010, 8'd4, "R5 no access done");
    rd(8'd0, 12'h011, 8'd4, "R5 misaligned read");
    idle(2);
    // R6 bounds and extended offsets, R10 aliasing
    wr(8'd0, 12'h100, 8'd4, 32'h0BAD_0BAD, "R6 plain func beyond 256");
    rd(8'd0, 12'hFFC, 8'd4, "R6 plain func at 0xFFC");
    rd(8'd0, 12'h000, 8'd4, "R6 no alias write on plain func");
    wr(8'd1, 12'h104, 8'd4, 32'hCAFE_F00D, "R6 ext func offset 0x104");
    rd(8'd1, 12'h004, 8'd4, "R10 alias of 0x104");
    rd(8'd1, 12'hFFC, 8'd4, "R6 ext func last word");
    wr(8'd3, 12'hFFF, 8'd1, 32'h0000_0077, "R6 ext func last byte");
    rd(8'd3, 12'h03C, 8'd4, "R10 alias of 0xFFF");
    rd(8'd0, 12'h0FC, 8'd4, "R6 plain func last word");
    idle(2);
    // R7 device and bridge selection
    send(1'b1, 4'd5, 4'd1, BID, mk_addr(8'd4, 12'h010), 8'd4, 32'h1, "R7 devfn 4");
    send(1'b0, 4'd4, 4'd2, BID, mk_addr(8'h80, 12'h010), 8'd4, 32'h0, "R7 devfn 0x80");
    send(1'b1, 4'd5, 4'd1, {32'h0000_0801, 32'h2000_0001}, mk_addr(8'd0, 12'h010), 8'd4, 32'h2, "R7 bridge high mismatch");
    send(1'b0, 4'd4, 4'd2, {32'h2000_0001, 32'h0000_0800}, mk_addr(8'd0, 12'h010), 8'd4, 32'h0, "R7 bridge halves swapped");
    rd(8'd0, 12'h010, 8'd4, "R7 storage untouched");
    // R3 / R11 argument counts
    send(1'b0, 4'd5, 4'd2, BID, mk_addr(8'd0, 12'h010), 8'd4, 32'h0, "R3 read nargs 5");
    send(1'b0, 4'd4, 4'd1, BID, mk_addr(8'd0, 12'h010), 8'd4, 32'h0, "R3 read nret 1");
    send(1'b1, 4'd5, 4'd2, BID, mk_addr(8'd0, 12'h010), 8'd4, 32'h3, "R3 write nret 2");
    send(1'b1, 4'd4, 4'd1, BID, mk_addr(8'd0, 12'h010), 8'd4, 32'h4, "R11 write nargs 4");
    rd(8'd0, 12'h010, 8'd4, "R3 storage untouched");
    idle(4);
    check(q.size() == 0, "R2 all responses seen", 32'(q.size()), 32'd0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule